// File: doc/BRIEF.md
# Seeded Direction Pattern Generator

This block turns an 8-bit seed into a repeatable pseudo-random stream of 2-bit direction codes. It holds an 8-stage shift register with linear feedback. The incoming bit is the XOR of stages 4, 3, 2 and 0, so the register runs through all 255 nonzero states. A load strobe copies the seed into the register. A next strobe moves the register two shift positions in one clock cycle. The two lowest register bits are the current pattern code. A decoder also presents that code as a one-hot direction vector.

Control is a two-state machine:
- `FSM_IDLE` is entered on reset and means no seed has been loaded yet.
- `FSM_RUN` is entered after a load.
- The transition IDLE→RUN happens on `load`.
- The transition RUN→RUN happens either on `load` (a reload) or on `next` (an advance).
- In IDLE, `next` is ignored.

A game controller loads the same seed before each replay and gets back the identical pattern sequence.

Top module: `lfsr_dir_gen`

## Requirements
- R1: After reset the register holds 8'h01 and the machine is in IDLE. The code output is therefore 2'b01 (RIGHT) and the direction output is 4'b0010.
- R2: In IDLE, a `next` strobe without `load` changes neither the register nor the outputs.
- R3: A `load` with a nonzero seed places the seed in the register at the clock edge. From the following cycle the code equals seed[1:0].
- R4: A `load` with an all-zero seed places 8'h01 in the register instead. The register never holds zero.
- R5: In RUN, a `next` strobe without `load` applies two single shifts in one cycle. A single shift moves each bit one place toward bit 0 and writes bit7 with s4^s3^s2^s0, taken from the register before that shift.
- R6: The code is register bits [1:0], encoded as 00=UP, 01=RIGHT, 10=LEFT, 11=DOWN. The direction output is one-hot with bit index equal to the code: bit0 UP, bit1 RIGHT, bit2 LEFT, bit3 DOWN. Both outputs follow the register within the same cycle.
- R7: When `load` and `next` are both high, only the load takes effect.
- R8: With `load` and `next` both low, the register and outputs hold.
- R9: Reloading the same seed reproduces the identical code sequence.
- R10: From any nonzero seed, 255 consecutive `next` strobes return the register to the seed. The visible code sequence then repeats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed | input | 8 | Value to load into the register |
| load | input | 1 | Copy the seed into the register (zero becomes 8'h01) |
| next | input | 1 | Advance to the next pattern (two shifts) |
| code | output | 2 | Current pattern code, register bits [1:0] |
| dir | output | 4 | One-hot decoded direction, bit index equal to the code |

## Verification
The following properties are checked on every cycle:
- the register is never zero;
- a load lands the seed, or 8'h01 for a zero seed;
- an advance shifts the old upper six bits into the low six;
- an idle cycle holds the register;
- IDLE persists until a load;
- the direction vector is one-hot and matches the code.

Some behaviours can only be shown by the bench's scenarios, which compare the codes against an independent model of the feedback:
- the exact values of the new feedback bits;
- load priority over next;
- repeating the sequence on reload;
- the 255-pattern period.

// File: rtl/lfsr_pat_pkg.sv
package lfsr_pat_pkg;

    typedef enum logic [1:0] {
        DIR_UP    = 2'd0,
        DIR_RIGHT = 2'd1,
        DIR_LEFT  = 2'd2,
        DIR_DOWN  = 2'd3
    } dir_e;

    typedef enum logic {
        FSM_IDLE = 1'b0,
        FSM_RUN  = 1'b1
    } fsm_e;

endpackage

// File: rtl/lfsr_pat_ctrl.sv
module lfsr_pat_ctrl
    import lfsr_pat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic next,
    output logic load_en,
    output logic adv_en
);

    fsm_e st_q;
    fsm_e st_d;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FSM_IDLE: if (load) st_d = FSM_RUN;
            FSM_RUN:  st_d = FSM_RUN;
            default:  st_d = FSM_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FSM_IDLE;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        load_en = 1'b0;
        adv_en  = 1'b0;
        unique case (st_q)
            FSM_IDLE: load_en = load;
            FSM_RUN: begin
                load_en = load;
                adv_en  = next && !load;
            end
            default: ;
        endcase
    end

    AST_IDLE_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FSM_IDLE && !load) |=> (st_q == FSM_IDLE)); // R2

    AST_LOAD_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !adv_en); // R7

endmodule

// File: rtl/lfsr_pat_core.sv
module lfsr_pat_core #(
    parameter int         W        = 8,
    parameter logic [W-1:0] TAP_MASK = 8'b0001_1101,
    parameter int         STEPS    = 2,
    parameter logic [W-1:0] SAFE_VAL = 8'h01
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic         adv_en,
    input  logic [W-1:0] seed,
    output logic [W-1:0] q
);

    localparam int LAST = STEPS;

    logic [LAST:0][W-1:0] chain;
    logic [W-1:0]         load_val;

    assign chain[0] = q;

    genvar i;
    generate
        for (i = 0; i < STEPS; i++) begin : g_shift
            assign chain[i+1] = {^(chain[i] & TAP_MASK), chain[i][W-1:1]};
        end
    endgenerate

    assign load_val = (seed == '0) ? SAFE_VAL : seed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= SAFE_VAL;
        else if (load_en) q <= load_val;
        else if (adv_en)  q <= chain[LAST];
    end

    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        q != '0); // R4

    AST_LOAD_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && seed != '0) |=> (q == $past(seed))); // R3

    AST_ZERO_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && seed == '0) |=> (q == SAFE_VAL)); // R4

    AST_ADV_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && !load_en) |=> (q[W-STEPS-1:0] == $past(q[W-1:STEPS]))); // R5

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !adv_en) |=> $stable(q)); // R8

endmodule

// File: rtl/lfsr_pat_decode.sv
module lfsr_pat_decode
    import lfsr_pat_pkg::*;
#(
    parameter int NDIR = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      code,
    output logic [NDIR-1:0] dir
);

    dir_e cur;
    assign cur = dir_e'(code);

    genvar k;
    generate
        for (k = 0; k < NDIR; k++) begin : g_dec
            assign dir[k] = (cur == dir_e'(k));
        end
    endgenerate

    AST_DIR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dir) == 1); // R6

    AST_DIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        dir[code] == 1'b1); // R6

endmodule

// File: rtl/lfsr_dir_gen.sv
module lfsr_dir_gen #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] seed,
    input  logic         load,
    input  logic         next,
    output logic [1:0]   code,
    output logic [3:0]   dir
);

    logic         load_en;
    logic         adv_en;
    logic [W-1:0] q;

    lfsr_pat_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .next    (next),
        .load_en (load_en),
        .adv_en  (adv_en)
    );

    lfsr_pat_core #(.W(W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .adv_en  (adv_en),
        .seed    (seed),
        .q       (q)
    );

    assign code = q[1:0];

    lfsr_pat_decode #(.NDIR(4)) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .code  (code),
        .dir   (dir)
    );

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && next && seed != '0) |=> (q == $past(seed))); // R7

endmodule

// File: tb/sim_lfsr_dir_gen.sv
module sim_lfsr_dir_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] seed = 8'h00;
    logic       load = 1'b0;
    logic       next = 1'b0;
    logic [1:0] code;
    logic [3:0] dir;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [7:0] m_reg;
    bit         m_run;

    always #4 clk = ~clk;

    lfsr_dir_gen u0 (
        .clk(clk), .rst_n(rst_n), .seed(seed),
        .load(load), .next(next), .code(code), .dir(dir)
    );

    function automatic logic [7:0] one_shift(input logic [7:0] s);
        return {s[4] ^ s[3] ^ s[2] ^ s[0], s[7:1]};
    endfunction

    function automatic logic [7:0] two_shift(input logic [7:0] s);
        return one_shift(one_shift(s));
    endfunction

    task automatic check_out(input string req);
        logic [3:0] exp_dir;
        exp_dir = 4'b0001 << m_reg[1:0];
        checks++;
        if (code !== m_reg[1:0] || dir !== exp_dir) begin
            errors++;
            $display("FAIL %s: code=%b dir=%b expected code=%b dir=%b",
                     req, code, dir, m_reg[1:0], exp_dir);
        end
    endtask

    // at negedge: drive, take edge, update model, sample at next negedge
    task automatic cyc(input logic l, input logic n, input logic [7:0] s, input string req);
        load = l; next = n; seed = s;
        @(posedge clk);
        if (l) begin
            m_reg = (s == 8'h00) ? 8'h01 : s;
            m_run = 1'b1;
        end else if (n && m_run) begin
            m_reg = two_shift(m_reg);
        end
        @(negedge clk);
        check_out(req);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [1:0] first_run [0:19];
        logic [7:0] sd;
        void'($urandom(32'd4242));
        m_reg = 8'h01;
        m_run = 1'b0;
        repeat (3) @(negedge clk);
        check_out("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 after release");

        // R2: next ignored in idle
        cyc(1'b0, 1'b1, 8'hA5, "R2 idle next");
        cyc(1'b0, 1'b1, 8'h00, "R2 idle next");

        // R3: nonzero load
        cyc(1'b1, 1'b0, 8'hB6, "R3 load");
        // R6 every code
        cyc(1'b1, 1'b0, 8'h10, "R6 UP");
        cyc(1'b1, 1'b0, 8'h11, "R6 RIGHT");
        cyc(1'b1, 1'b0, 8'h12, "R6 LEFT");
        cyc(1'b1, 1'b0, 8'h13, "R6 DOWN");

        // R4: zero seed
        cyc(1'b1, 1'b0, 8'h00, "R4 zero seed");
        // R5: advances from the safe value
        for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1, 8'h00, "R5 advance");

        // R7: load beats next
        cyc(1'b1, 1'b1, 8'h5C, "R7 load and next");
        // R8: hold
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 8'hFF, "R8 hold");

        // R9: reload reproduces
        cyc(1'b1, 1'b0, 8'h3D, "R9 load");
        for (int i = 0; i < 20; i++) begin
            cyc(1'b0, 1'b1, 8'h00, "R9 first run");
            first_run[i] = code;
        end
        cyc(1'b1, 1'b0, 8'h3D, "R9 reload");
        for (int i = 0; i < 20; i++) begin
            cyc(1'b0, 1'b1, 8'h00, "R9 replay");
            checks++;
            if (code !== first_run[i]) begin
                errors++;
                $display("FAIL R9 replay %0d: code=%b expected %b", i, code, first_run[i]);
            end
        end

        // R10: period 255
        cyc(1'b1, 1'b0, 8'hE1, "R10 load");
        for (int i = 0; i < 255; i++) cyc(1'b0, 1'b1, 8'h00, "R10 walk");
        checks++;
        if (m_reg !== 8'hE1) begin
            errors++;
            $display("FAIL R10 model period: reg=%h expected e1", m_reg);
        end

        // random mix
        for (int i = 0; i < 600; i++) begin
            sd = 8'($urandom);
            if ((i % 97) == 0) sd = 8'h00;
            cyc(($urandom % 8) == 0, ($urandom % 3) != 0, sd, "R5 R7 R8 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule